// File: doc/BRIEF.md
# Clock-Enable Divider with Guarded Ratio Change

This block divides an incoming clock-enable stream by an integer ratio. Each time the input enable is high, an internal counter advances. When the counter reaches the end of the current ratio, the block raises its output enable for one cycle. The output therefore pulses once for every N input enables. The ratio comes from a small control register, and the register decodes it in one of two ways, chosen by a parameter:

- **Linear:** the code plus one, times a fixed prescale.
- **Table:** the code selects an entry in a lookup table held as a parameter. The first zero entry marks the end of the usable codes.

A new ratio does not take effect at the moment it is written. Software writes the divide code with a change-enable bit set, and a busy flag then rises. The old ratio keeps running to the end of its current output period. The new ratio is loaded at that boundary and busy drops, so the output never carries a shortened or stretched period made of two ratios.

A stop bit holds the output low. A parameter mask marks some parent-select values as bypassed; for those parents the ratio is forced to one and the stored code has no effect.

Top module: `clkdiv_ce`

## Requirements
- R1: In linear mode the ratio is (code+1)*PRESCALE, where the code is write/read bits [DIV_W-1:0] (bits [3:0] by default). With the default PRESCALE=2, codes 0, 1, 3, 6 and 15 give ratios 2, 4, 8, 14 and 32, measured with the input enable held high.
- R2: In table mode the ratio is table entry [code]. A code at or beyond the first zero entry is rejected: busy stays 0 and the running ratio is unchanged, although the code is still stored. With the default table {1,3,5,7,0,...}, codes 0, 2 and 3 give ratios 1, 5 and 7, and code 6 is rejected.
- R3: When BYPASS_MASK[parent_sel] is 1, the output enable follows every input enable (ratio 1) whatever code is stored. The default mask bypasses parent 2.
- R4: A write with change-enable (write bit DIV_W, bit 4 by default) carrying a valid code starts an update. The same write clears the stop bit.
- R5: Busy (read bit DIV_W+2, bit 6 by default) reads 1 from the cycle after an accepted write until the new ratio is in effect, then reads 0.
- R6: After an accepted write, the old ratio completes its current output period, and the new ratio governs every period after it.
- R7: While stop (write/read bit DIV_W+1, bit 5 by default) is 1, the output enable stays 0 and the counter is held at zero.
- R8: A write without change-enable updates the stored code (readable at once) and the stop bit, but not the running ratio.
- R9: The counter advances only on input enables, and the output enable is high only in cycles where the input enable is high. A ratio of 8 with an input enable every third cycle gives an output period of 24 cycles.
- R10: After reset the register reads all zero (code 0, not stopped, not busy), and the running ratio is the decoded value of code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DIV_W+2 | Write data: code, change-enable, stop |
| rd_data | output | DIV_W+3 | Read data: code, 0, stop, busy |
| parent_sel | input | PSEL_W | Currently selected parent, indexes the bypass mask |
| src_ce | input | 1 | Incoming clock-enable |
| out_ce | output | 1 | Divided clock-enable |

## Verification
The hardest case is a ratio write that lands exactly at a period boundary. In that case the old period must still run in full while busy is high. The stimulus waits for an output pulse and issues the write in the next cycle, so the counter restarts as the update arrives. It then expects the full old period of 32 cycles before a first period of 4. A restart out of stop with a changed code is handled the same way. The first period must still use the ratio that was running before the stop.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Linear ratio: (code + 1) scaled by the prescale factor.
  function automatic int unsigned lin_ratio(input int unsigned code,
                                            input int unsigned prescale);
    return (code + 1) * prescale;
  endfunction

  // Write-port command bits above the code field.
  typedef struct packed {
    logic stop;
    logic chg;
  } wr_cmd_t;

endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode #(
  parameter int unsigned DIV_W     = 4,
  parameter int unsigned PRESCALE  = 2,
  parameter bit          USE_TABLE = 1'b0,
  parameter int unsigned TBL_W     = 8,
  parameter int unsigned DV_W      = 8,
  parameter logic [(2**DIV_W)*TBL_W-1:0] DIV_TABLE = '0
) (
  input  logic [DIV_W-1:0] code,
  output logic [DV_W-1:0]  ratio,
  output logic             valid
);
  localparam int unsigned NENT = 2 ** DIV_W;

  generate
    if (USE_TABLE) begin : g_table
      always_comb begin
        logic ended;
        ended = 1'b0;
        ratio = '0;
        valid = 1'b0;
        for (int i = 0; i < NENT; i++) begin
          if (DIV_TABLE[i*TBL_W +: TBL_W] == '0) ended = 1'b1;
          if (DIV_W'(i) == code && !ended) begin
            valid = 1'b1;
            ratio = DV_W'(DIV_TABLE[i*TBL_W +: TBL_W]);
          end
        end
      end
    end else begin : g_linear
      always_comb begin
        ratio = DV_W'(clkdiv_pkg::lin_ratio(int'(code), PRESCALE));
        valid = 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl #(
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned DV_W    = 8,
  parameter logic [DV_W-1:0] RST_RATIO = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_code,
  input  clkdiv_pkg::wr_cmd_t wr_cmd,
  input  logic [DV_W-1:0]  dec_ratio,
  input  logic             dec_valid,
  input  logic             period_end,
  output logic [DIV_W-1:0] code_q,
  output logic             stop_q,
  output logic             busy_q,
  output logic [DV_W-1:0]  active_ratio
);
  logic [DV_W-1:0] pend_ratio;
  logic            apply_now;
  logic            accept;

  assign apply_now = busy_q && period_end;
  assign accept    = wr_en && wr_cmd.chg && dec_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q       <= '0;
      stop_q       <= 1'b0;
      busy_q       <= 1'b0;
      active_ratio <= RST_RATIO;
      pend_ratio   <= '0;
    end else begin
      if (apply_now) begin
        active_ratio <= pend_ratio;
        busy_q       <= 1'b0;
      end
      if (wr_en) begin
        code_q <= wr_code;
        if (wr_cmd.chg) begin
          stop_q <= 1'b0;
        end else begin
          stop_q <= wr_cmd.stop;
        end
      end
      if (accept) begin
        pend_ratio <= dec_ratio;
        busy_q     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int unsigned DV_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_ce,
  input  logic            stop,
  input  logic [DV_W-1:0] eff_ratio,
  output logic            out_ce,
  output logic [DV_W-1:0] cnt
);
  logic terminal;

  // >= so that a ratio shrinking under an active count still ends the period
  assign terminal = (cnt >= eff_ratio - DV_W'(1));
  assign out_ce   = src_ce && !stop && terminal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (stop) begin
      cnt <= '0;
    end else if (src_ce) begin
      cnt <= terminal ? '0 : cnt + DV_W'(1);
    end
  end
endmodule

// File: rtl/clkdiv_ce.sv
module clkdiv_ce #(
  parameter int unsigned DIV_W     = 4,
  parameter int unsigned PRESCALE  = 2,
  parameter bit          USE_TABLE = 1'b0,
  parameter int unsigned TBL_W     = 8,
  parameter logic [(2**DIV_W)*TBL_W-1:0] DIV_TABLE = 128'h0000_0000_0000_0000_0000_0000_0705_0301,
  parameter int unsigned PSEL_W    = 2,
  parameter logic [(2**PSEL_W)-1:0] BYPASS_MASK = 4'b0100,
  localparam int unsigned WD_W     = DIV_W + 2,
  localparam int unsigned RD_W     = DIV_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WD_W-1:0]   wr_data,
  output logic [RD_W-1:0]   rd_data,
  input  logic [PSEL_W-1:0] parent_sel,
  input  logic              src_ce,
  output logic              out_ce
);
  localparam int unsigned LIN_W = $clog2((PRESCALE << DIV_W) + 1);
  localparam int unsigned DV_W  = USE_TABLE ? TBL_W : LIN_W;
  localparam logic [DV_W-1:0] RST_RATIO =
    USE_TABLE ? DV_W'(DIV_TABLE[TBL_W-1:0]) : DV_W'(PRESCALE);

  logic [DIV_W-1:0]    wr_code;
  clkdiv_pkg::wr_cmd_t wr_cmd;
  logic [DV_W-1:0]     dec_ratio;
  logic                dec_valid;
  logic [DIV_W-1:0]    code_q;
  logic                stop_q;
  logic                busy_q;
  logic [DV_W-1:0]     active_ratio;
  logic [DV_W-1:0]     eff_ratio;
  logic [DV_W-1:0]     cnt;
  logic                bypass_hit;

  assign wr_code = wr_data[DIV_W-1:0];
  assign wr_cmd  = wr_data[WD_W-1:DIV_W];

  clkdiv_decode #(
    .DIV_W(DIV_W), .PRESCALE(PRESCALE), .USE_TABLE(USE_TABLE),
    .TBL_W(TBL_W), .DV_W(DV_W), .DIV_TABLE(DIV_TABLE)
  ) u_decode (
    .code  (wr_code),
    .ratio (dec_ratio),
    .valid (dec_valid)
  );

  clkdiv_ctrl #(
    .DIV_W(DIV_W), .DV_W(DV_W), .RST_RATIO(RST_RATIO)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_code      (wr_code),
    .wr_cmd       (wr_cmd),
    .dec_ratio    (dec_ratio),
    .dec_valid    (dec_valid),
    .period_end   (out_ce),
    .code_q       (code_q),
    .stop_q       (stop_q),
    .busy_q       (busy_q),
    .active_ratio (active_ratio)
  );

  assign bypass_hit = BYPASS_MASK[parent_sel];
  assign eff_ratio  = (bypass_hit || active_ratio == '0) ? DV_W'(1) : active_ratio;

  clkdiv_counter #(.DV_W(DV_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_ce    (src_ce),
    .stop      (stop_q),
    .eff_ratio (eff_ratio),
    .out_ce    (out_ce),
    .cnt       (cnt)
  );

  assign rd_data = {busy_q, stop_q, 1'b0, code_q};
endmodule

// File: rtl/clkdiv_ce_chk.sv
module clkdiv_ce_chk #(
  parameter int unsigned DIV_W = 4,
  parameter int unsigned DV_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [DIV_W+1:0] wr_data,
  input logic             dec_valid,
  input logic             src_ce,
  input logic             out_ce,
  input logic             busy_q,
  input logic             stop_q,
  input logic [DV_W-1:0]  cnt,
  input logic [DV_W-1:0]  active_ratio
);
  // R9
  out_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ce |-> src_ce);

  // R7
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> !out_ce);

  // R7
  stop_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> (cnt == '0));

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[DIV_W] && dec_valid) |=> busy_q);

  // R5
  busy_fall_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(out_ce));

  // R6
  ratio_swap_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_ratio) |-> $past(busy_q && out_ce));

  // R4
  chg_clears_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[DIV_W]) |=> !stop_q);
endmodule

bind clkdiv_ce clkdiv_ce_chk #(.DIV_W(DIV_W), .DV_W(DV_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .dec_valid    (dec_valid),
  .src_ce       (src_ce),
  .out_ce       (out_ce),
  .busy_q       (busy_q),
  .stop_q       (stop_q),
  .cnt          (cnt),
  .active_ratio (active_ratio)
);

// File: tb/clkdiv_ce_bench.sv
`timescale 1ns/1ps
module clkdiv_ce_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en_l = 1'b0, wr_en_t = 1'b0;
  logic [5:0] wr_data = '0;
  logic [6:0] rd_l, rd_t;
  logic [1:0] parent_sel = 2'd0;
  logic       src_ce = 1'b0;
  logic       out_l, out_t;
  int         ce_space = 1;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  clkdiv_ce u_clkdiv_ce (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_l), .wr_data(wr_data),
    .rd_data(rd_l), .parent_sel(parent_sel), .src_ce(src_ce), .out_ce(out_l));

  clkdiv_ce #(.USE_TABLE(1'b1)) u_clkdiv_ce_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_t), .wr_data(wr_data),
    .rd_data(rd_t), .parent_sel(parent_sel), .src_ce(src_ce), .out_ce(out_t));

  // input enable source: one pulse every ce_space cycles, changed away from edges
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(posedge clk);
      #3;
      ph = (ph + 1 >= ce_space) ? 0 : ph + 1;
      src_ce = (ph == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic outv(input bit t);
    return t ? out_t : out_l;
  endfunction

  function automatic logic [6:0] rdv(input bit t);
    return t ? rd_t : rd_l;
  endfunction

  task automatic do_write(input bit t, input logic [5:0] d);
    @(negedge clk);
    wr_data = d;
    if (t) wr_en_t = 1'b1; else wr_en_l = 1'b1;
    @(negedge clk);
    wr_en_t = 1'b0;
    wr_en_l = 1'b0;
  endtask

  task automatic wait_idle(input bit t);
    for (int i = 0; i < 400 && rdv(t)[6]; i++) @(negedge clk);
  endtask

  task automatic measure(input bit t, output int n);
    int w;
    w = 0;
    do begin @(negedge clk); w++; end while (!outv(t) && w < 2000);
    n = 0;
    do begin @(negedge clk); n++; end while (!outv(t) && n < 2000);
  endtask

  localparam int NV = 5;
  localparam int VEC [NV][2] = '{'{0, 2}, '{1, 4}, '{3, 8}, '{15, 32}, '{6, 14}};

  initial begin
    int n;
    int b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state and default ratio
    chk("R10 rd_data", int'(rd_l), 0);
    measure(1'b0, n);
    chk("R10 reset ratio", n, 2);

    // R1 / R5 vector walk
    for (int v = 0; v < NV; v++) begin
      do_write(1'b0, 6'b010000 | 6'(VEC[v][0]));
      chk("R5 busy after write", int'(rd_l[6]), 1);
      wait_idle(1'b0);
      chk("R5 busy clears", int'(rd_l[6]), 0);
      measure(1'b0, n);
      chk("R1 linear ratio", n, VEC[v][1]);
    end

    // R8 write without change-enable
    do_write(1'b0, 6'd9);
    chk("R8 code stored", int'(rd_l[3:0]), 9);
    measure(1'b0, n);
    chk("R8 ratio unchanged", n, 14);

    // R6 write right at a period boundary: 32 then 4
    do_write(1'b0, 6'b011111);
    wait_idle(1'b0);
    do @(negedge clk); while (!out_l);
    wr_data = 6'b010001;
    wr_en_l = 1'b1;
    n = 0;
    b = 0;
    do begin
      @(negedge clk);
      wr_en_l = 1'b0;
      n++;
      if (n == 30) b = int'(rd_l[6]);
    end while (!out_l && n < 2000);
    chk("R6 old period kept", n, 32);
    chk("R5 busy during old period", b, 1);
    measure(1'b0, n);
    chk("R6 new ratio", n, 4);

    // R7 stop holds output low
    do_write(1'b0, 6'b100001);
    chk("R7 stop reads back", int'(rd_l[5]), 1);
    b = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (out_l) b++; end
    chk("R7 no pulses while stopped", b, 0);
    // restart with code 3: old ratio 4 first, then 8
    @(negedge clk);
    wr_data = 6'b010011;
    wr_en_l = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      wr_en_l = 1'b0;
      n++;
      if (n == 1) chk("R4 stop cleared", int'(rd_l[5]), 0);
    end while (!out_l && n < 2000);
    chk("R7 first period after restart", n, 4);
    measure(1'b0, n);
    chk("R6 ratio after restart", n, 8);

    // R9 sparse input enable
    ce_space = 3;
    measure(1'b0, n);
    measure(1'b0, n);
    chk("R9 sparse period", n, 24);
    ce_space = 1;
    measure(1'b0, n);

    // R3 bypass
    parent_sel = 2'd2;
    measure(1'b0, n);
    chk("R3 bypass ratio", n, 1);
    do_write(1'b0, 6'b011111);
    wait_idle(1'b0);
    measure(1'b0, n);
    chk("R3 code ignored in bypass", n, 1);
    parent_sel = 2'd1;
    measure(1'b0, n);
    measure(1'b0, n);
    chk("R3 unbypassed parent", n, 32);
    parent_sel = 2'd0;

    // R2 table mode
    measure(1'b1, n);
    chk("R2 table reset ratio", n, 1);
    do_write(1'b1, 6'b010010);
    wait_idle(1'b1);
    measure(1'b1, n);
    chk("R2 table code 2", n, 5);
    do_write(1'b1, 6'b010110);
    chk("R2 rejected code no busy", int'(rd_t[6]), 0);
    chk("R2 rejected code stored", int'(rd_t[3:0]), 6);
    measure(1'b1, n);
    chk("R2 rejected code keeps ratio", n, 5);
    do_write(1'b1, 6'b010011);
    wait_idle(1'b1);
    measure(1'b1, n);
    chk("R2 table code 3", n, 7);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule